// File: doc/BRIEF.md
# Rename Checkpoint Diff and Rewrite Sequencer

This block sits next to a register map table in an out-of-order core that keeps control-independent work alive across a branch mispredict. When a branch is flagged as low-confidence, the block starts recording which architectural registers get renamed. Just before the instruction at the predicted convergence point is renamed, it takes a snapshot of the whole map. This snapshot holds the wrong-path mappings seen by the control-independent instructions.

If the branch turns out mispredicted, the front end renames the correct-path control-dependent instructions and then signals that the refill is complete. At that point the block compares the snapshot with the live map. It walks the registers that were recorded and whose tags differ, and emits one (wrong-path tag, correct-path tag) pair per cycle. It holds a stall request for the whole walk. Consumers use each pair as a search-and-replace on issue queue tags and on younger map checkpoints. The repair cost therefore scales with the number of changed registers, not with the number of control-independent instructions. If the branch resolves correctly, the tracking state is discarded at no cost.

Top module: `ckpt_rewrite_seq`

## Requirements
- R1: After reset, stall_o, rw_valid_o and done_o are low.
- R2: Recording starts only when lowconf_br_i is seen while idle. Rename writes made before that are not recorded.
- R3: The snapshot is the value of map_i in the cycle when conv_i is high. A rename write in that same cycle belongs to the convergence instruction and is not recorded.
- R4: Each pair carries rw_old_o, the snapshot tag of one register, and rw_new_o, the live map_i tag of the same register. A register is walked if it was written after the branch and before the convergence point, or while the correct path was being refilled.
- R5: Pairs come out one per consecutive cycle, in ascending architectural register index. Registers that are skipped cost no cycles.
- R6: A recorded register whose snapshot tag equals its live tag produces no pair. A register that was never recorded produces no pair, even if its tag differs.
- R7: stall_o rises in the cycle after refill_done_i. done_o pulses for one cycle right after the last pair, or in the first walk cycle if there are no pairs, with stall_o still high. stall_o is low in the following cycle.
- R8: A second lowconf_br_i while tracking is already active is ignored, and the recorded set is kept.
- R9: br_ok_i during tracking or while the snapshot is held drops all state. mispred_i before the convergence snapshot also drops all state. In both cases no walk or stall follows a later refill_done_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lowconf_br_i | input | 1 | Low-confidence branch renamed; start recording |
| conv_i | input | 1 | Convergence instruction about to rename; take snapshot |
| br_ok_i | input | 1 | Tracked branch resolved as predicted |
| mispred_i | input | 1 | Tracked branch mispredicted; correct-path refill begins |
| refill_done_i | input | 1 | Correct-path control-dependent refill finished |
| ren_we_i | input | 1 | Rename writes a destination this cycle |
| ren_areg_i | input | $clog2(NUM_AREGS) | Architectural destination of the rename write |
| map_i | input | NUM_AREGS*PTAG_W | Live map, register r at bits [r*PTAG_W +: PTAG_W] |
| rw_valid_o | output | 1 | Rewrite pair valid |
| rw_old_o | output | PTAG_W | Wrong-path (snapshot) tag |
| rw_new_o | output | PTAG_W | Correct-path (live) tag |
| done_o | output | 1 | Walk complete pulse |
| stall_o | output | 1 | Pipeline stall request during the walk |

## Verification
The assertions assume that the map table does not change while stall_o is high, and that refill_done_i is raised only after a mispredict on a branch with a snapshot in place. The bench holds map_i fixed from the refill_done_i pulse until stall_o falls. It applies refill_done_i in other states only in scenarios that check it is ignored. Under those conditions every emitted pair has differing tags, the indices rise strictly, and stall_o follows refill_done_i and ends one cycle after done_o.

// File: rtl/crw_pkg.sv
package crw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_TRACK,
    S_HELD,
    S_REFILL,
    S_WALK
  } crw_state_e;
endpackage

// File: rtl/crw_track.sv
module crw_track #(
  parameter int NUM_AREGS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         rec_i,
  input  logic                         we_i,
  input  logic [$clog2(NUM_AREGS)-1:0] areg_i,
  output logic [NUM_AREGS-1:0]         written_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            written_o <= '0;
    else if (clear_i)       written_o <= '0;
    else if (rec_i && we_i) written_o[areg_i] <= 1'b1;
  end
endmodule

// File: rtl/crw_ckpt.sv
module crw_ckpt #(
  parameter int NUM_AREGS = 16,
  parameter int PTAG_W    = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          capture_i,
  input  logic [NUM_AREGS*PTAG_W-1:0]   map_i,
  output logic [NUM_AREGS*PTAG_W-1:0]   ckpt_o
);
  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ckpt_o[g*PTAG_W +: PTAG_W] <= '0;
      else if (capture_i) ckpt_o[g*PTAG_W +: PTAG_W] <= map_i[g*PTAG_W +: PTAG_W];
    end
  end
endmodule

// File: rtl/crw_walk.sv
module crw_walk #(
  parameter int NUM_AREGS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         active_i,
  input  logic [NUM_AREGS-1:0]         cand_i,
  output logic                         any_o,
  output logic [$clog2(NUM_AREGS)-1:0] idx_o
);
  localparam int AIDX_W = $clog2(NUM_AREGS);

  logic [NUM_AREGS-1:0] served_q;
  logic [NUM_AREGS-1:0] pend;

  assign pend  = cand_i & ~served_q;
  assign any_o = |pend;

  // lowest pending index wins
  always_comb begin
    idx_o = '0;
    for (int i = NUM_AREGS - 1; i >= 0; i--) begin
      if (pend[i]) idx_o = AIDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        served_q <= '0;
    else if (!active_i) served_q <= '0;
    else if (any_o)     served_q[idx_o] <= 1'b1;
  end
endmodule

// File: rtl/ckpt_rewrite_seq.sv
module ckpt_rewrite_seq #(
  parameter int NUM_AREGS = 16,
  parameter int PTAG_W    = 6
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         lowconf_br_i,
  input  logic                         conv_i,
  input  logic                         br_ok_i,
  input  logic                         mispred_i,
  input  logic                         refill_done_i,
  input  logic                         ren_we_i,
  input  logic [$clog2(NUM_AREGS)-1:0] ren_areg_i,
  input  logic [NUM_AREGS*PTAG_W-1:0]  map_i,
  output logic                         rw_valid_o,
  output logic [PTAG_W-1:0]            rw_old_o,
  output logic [PTAG_W-1:0]            rw_new_o,
  output logic                         done_o,
  output logic                         stall_o
);
  import crw_pkg::*;

  localparam int AIDX_W = $clog2(NUM_AREGS);

  crw_state_e state_q, state_d;

  logic                         clear_w, rec_w, capture_w, walking;
  logic [NUM_AREGS-1:0]         written;
  logic [NUM_AREGS*PTAG_W-1:0]  ckpt_flat;
  logic [NUM_AREGS-1:0]         cand;
  logic                         walk_any;
  logic [AIDX_W-1:0]            walk_idx;

  assign walking   = (state_q == S_WALK);
  assign clear_w   = (state_q == S_IDLE) && lowconf_br_i;
  assign capture_w = (state_q == S_TRACK) && conv_i && !br_ok_i && !mispred_i;
  // convergence instruction's own write is not part of the region
  assign rec_w     = ((state_q == S_TRACK) && !conv_i && !br_ok_i && !mispred_i) ||
                     (state_q == S_REFILL);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:   if (lowconf_br_i) state_d = S_TRACK;
      S_TRACK:  if (br_ok_i || mispred_i) state_d = S_IDLE;
                else if (conv_i)          state_d = S_HELD;
      S_HELD:   if (br_ok_i)        state_d = S_IDLE;
                else if (mispred_i) state_d = S_REFILL;
      S_REFILL: if (refill_done_i)  state_d = S_WALK;
      S_WALK:   if (!walk_any)      state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  crw_track #(.NUM_AREGS(NUM_AREGS)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_w),
    .rec_i     (rec_w),
    .we_i      (ren_we_i),
    .areg_i    (ren_areg_i),
    .written_o (written)
  );

  crw_ckpt #(.NUM_AREGS(NUM_AREGS), .PTAG_W(PTAG_W)) u_ckpt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_w),
    .map_i     (map_i),
    .ckpt_o    (ckpt_flat)
  );

  for (genvar g = 0; g < NUM_AREGS; g++) begin : g_diff
    assign cand[g] = written[g] &&
                     (ckpt_flat[g*PTAG_W +: PTAG_W] != map_i[g*PTAG_W +: PTAG_W]);
  end

  crw_walk #(.NUM_AREGS(NUM_AREGS)) u_walk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (walking),
    .cand_i   (cand),
    .any_o    (walk_any),
    .idx_o    (walk_idx)
  );

  assign rw_valid_o = walking && walk_any;
  assign rw_old_o   = ckpt_flat[walk_idx*PTAG_W +: PTAG_W];
  assign rw_new_o   = map_i[walk_idx*PTAG_W +: PTAG_W];
  assign done_o     = walking && !walk_any;
  assign stall_o    = walking;
endmodule

// File: rtl/crw_checker.sv
module crw_checker #(
  parameter int NUM_AREGS = 16,
  parameter int PTAG_W    = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         refill_done_i,
  input logic                         rw_valid_o,
  input logic [PTAG_W-1:0]            rw_old_o,
  input logic [PTAG_W-1:0]            rw_new_o,
  input logic                         done_o,
  input logic                         stall_o,
  input logic [$clog2(NUM_AREGS)-1:0] walk_idx
);
  AST_PAIR_UNDER_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_valid_o |-> stall_o); // R7
  AST_PAIR_DIFFERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_valid_o |-> (rw_old_o != rw_new_o)); // R6
  AST_ASCENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rw_valid_o && $past(rw_valid_o)) |-> (walk_idx > $past(walk_idx))); // R5
  AST_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !done_o) |=> stall_o); // R5
  AST_STALL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !stall_o); // R7
  AST_STALL_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_o) |-> $past(refill_done_i)); // R7
  AST_DONE_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rw_valid_o && stall_o)); // R7
endmodule

bind ckpt_rewrite_seq crw_checker #(.NUM_AREGS(NUM_AREGS), .PTAG_W(PTAG_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .refill_done_i (refill_done_i),
  .rw_valid_o    (rw_valid_o),
  .rw_old_o      (rw_old_o),
  .rw_new_o      (rw_new_o),
  .done_o        (done_o),
  .stall_o       (stall_o),
  .walk_idx      (walk_idx)
);

// File: tb/ckpt_rewrite_seq_test.sv
module ckpt_rewrite_seq_test;
  localparam int NA = 16;
  localparam int PW = 6;
  localparam int AW = $clog2(NA);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, lowconf, conv, br_ok, mispred, refill_done, ren_we;
  logic [AW-1:0] ren_areg;
  logic [NA*PW-1:0] map_flat;
  logic rw_valid, done, stall;
  logic [PW-1:0] rw_old, rw_new;

  logic [PW-1:0] map_m  [NA];
  logic [PW-1:0] base_m [NA];
  logic [PW-1:0] ckpt_m [NA];
  logic [NA-1:0] written_m;

  int n_chk = 0;
  int n_fail = 0;

  always_comb
    for (int r = 0; r < NA; r++) map_flat[r*PW +: PW] = map_m[r];

  ckpt_rewrite_seq #(.NUM_AREGS(NA), .PTAG_W(PW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .lowconf_br_i(lowconf), .conv_i(conv),
    .br_ok_i(br_ok), .mispred_i(mispred), .refill_done_i(refill_done),
    .ren_we_i(ren_we), .ren_areg_i(ren_areg), .map_i(map_flat),
    .rw_valid_o(rw_valid), .rw_old_o(rw_old), .rw_new_o(rw_new),
    .done_o(done), .stall_o(stall)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_lowconf(bit from_idle);
    lowconf = 1'b1; tick(); lowconf = 1'b0;
    if (from_idle) written_m = '0;
  endtask

  task automatic pulse_conv();
    for (int r = 0; r < NA; r++) ckpt_m[r] = map_m[r];
    conv = 1'b1; tick(); conv = 1'b0;
  endtask

  task automatic pulse_mispred();
    mispred = 1'b1; tick(); mispred = 1'b0;
  endtask

  task automatic pulse_br_ok();
    br_ok = 1'b1; tick(); br_ok = 1'b0;
  endtask

  task automatic wr(int a, int tag, bit rec);
    ren_we = 1'b1; ren_areg = AW'(a);
    map_m[a] = PW'(tag);
    if (rec) written_m[a] = 1'b1;
    tick();
    ren_we = 1'b0;
  endtask

  task automatic init_map();
    for (int r = 0; r < NA; r++) begin
      base_m[r] = PW'(r + 1);
      map_m[r]  = PW'(r + 1);
    end
  endtask

  task automatic restore_map();
    for (int r = 0; r < NA; r++) map_m[r] = base_m[r];
  endtask

  // drives refill_done and checks the whole walk against the model
  task automatic expect_walk(string req);
    refill_done = 1'b1; tick(); refill_done = 1'b0;
    for (int r = 0; r < NA; r++) begin
      if (written_m[r] && ckpt_m[r] != map_m[r]) begin
        chk(rw_valid === 1'b1, {req, " R5 pair valid"}, int'(rw_valid), 1);
        chk(rw_old == ckpt_m[r], {req, " R4 old tag"}, int'(rw_old), int'(ckpt_m[r]));
        chk(rw_new == map_m[r], {req, " R4 new tag"}, int'(rw_new), int'(map_m[r]));
        chk(stall === 1'b1, {req, " R7 stall in walk"}, int'(stall), 1);
        tick();
      end
    end
    chk(done === 1'b1 && rw_valid === 1'b0, {req, " R7 done pulse"}, int'(done), 1);
    chk(stall === 1'b1, {req, " R7 stall with done"}, int'(stall), 1);
    tick();
    chk(stall === 1'b0 && done === 1'b0, {req, " R7 stall released"}, int'(stall), 0);
  endtask

  task automatic expect_quiet(string req);
    refill_done = 1'b1; tick(); refill_done = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(stall === 1'b0 && rw_valid === 1'b0, req, int'(stall), 0);
      tick();
    end
  endtask

  // R4 R5: wrong path and refill both write; four pairs ascending
  task automatic t_basic();
    init_map();
    pulse_lowconf(1'b1);
    wr(9, 42, 1'b1); wr(2, 40, 1'b1); wr(5, 41, 1'b1);
    pulse_conv();
    pulse_mispred();
    restore_map();
    wr(3, 50, 1'b1); wr(5, 51, 1'b1);
    expect_walk("basic");
  endtask

  // R6 R2 R3: equal tags, unrecorded changes, convergence-cycle write
  task automatic t_skips();
    init_map();
    wr(11, 20, 1'b0);               // before branch: R2
    pulse_lowconf(1'b1);
    wr(4, 5, 1'b1);                 // written, tag unchanged: R6
    wr(0, 33, 1'b1);
    ren_we = 1'b1; ren_areg = AW'(8);
    pulse_conv();                   // write during conv: R3
    ren_we = 1'b0;
    pulse_mispred();
    map_m[11] = 6'd21; map_m[8] = 6'd22; map_m[7] = 6'd23;
    map_m[0] = 6'd1;
    wr(15, 60, 1'b1);
    expect_walk("skips");
  endtask

  // R6: nothing differs, done on first walk cycle
  task automatic t_empty();
    init_map();
    pulse_lowconf(1'b1);
    wr(6, 7, 1'b1);
    pulse_conv();
    pulse_mispred();
    expect_walk("empty R6");
  endtask

  // R8: second low-confidence branch keeps recorded set
  task automatic t_second_branch();
    init_map();
    pulse_lowconf(1'b1);
    wr(1, 30, 1'b1);
    pulse_lowconf(1'b0);
    wr(6, 31, 1'b1);
    pulse_conv();
    pulse_mispred();
    restore_map();
    expect_walk("second branch R8");
  endtask

  // R9: correct prediction and early mispredict drop state
  task automatic t_discard();
    init_map();
    pulse_lowconf(1'b1);
    wr(1, 30, 1'b1);
    pulse_conv();
    pulse_br_ok();
    pulse_mispred();
    restore_map();
    expect_quiet("FAIL-free R9 br_ok held");
    init_map();
    pulse_lowconf(1'b1);
    wr(4, 33, 1'b1);
    pulse_mispred();
    pulse_conv();
    pulse_mispred();
    restore_map();
    expect_quiet("R9 early mispredict");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
    report();
  end

  initial begin
    rst_n = 1'b0; lowconf = 1'b0; conv = 1'b0; br_ok = 1'b0; mispred = 1'b0;
    refill_done = 1'b0; ren_we = 1'b0; ren_areg = '0; written_m = '0;
    init_map();
    for (int r = 0; r < NA; r++) ckpt_m[r] = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(stall === 1'b0, "R1 stall at reset", int'(stall), 0);
    chk(rw_valid === 1'b0, "R1 valid at reset", int'(rw_valid), 0);
    chk(done === 1'b0, "R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    tick();
    t_basic();
    t_skips();
    t_empty();
    t_second_branch();
    t_discard();
    t_basic();
    report();
  end
endmodule